// File: doc/BRIEF.md
# Scanline Base Address and Pixel Pan Generator

This block produces the frame-buffer byte address at which each displayed scanline begins. Software programs a start address, a line pitch and a line-compare count through a small byte-wide register port. At every frame-start strobe from the timing generator the block loads the start address. At every line-start strobe it steps the address forward by one pitch. When the line counter reaches the compare count, the address falls back to zero, which gives a split screen whose lower part shows the top of memory.

The start address is held as a count of 32-bit words. The two byte-offset bits below the word address are not added to the address. They leave the block as a pixel-pan value instead, and its encoding depends on the selected colour depth. The start address and the pan are captured only at frame start, so software may rewrite them at any time without tearing the frame being shown. Memory fetch is outside this block.

Top module: `scan_base_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first frame start, `line_base` is 0 and `pan` is 0.
- R2: Register select codes are: 0 = start address bits 9:2, 1 = start address bits 17:10, 2 = start address bits 18 and up (register bits EXT_W-1:0), 7 = start byte offset (bits 1:0), 3 = pitch bits 7:0, 4 = pitch bits 15:8, 5 = line-compare bits 7:0, 6 = line-compare bits 15:8 (truncated to LINE_W). A write happens on a clock edge with `reg_wr` high.
- R3: One cycle after a `frame_start` strobe, `line_base` equals the word-aligned start address: {ext, high, low, 2'b00}, which is 18+EXT_W bits wide.
- R4: Each `line_start` strobe without `frame_start` advances `line_base` by pitch × 8 bytes, modulo 2^(18+EXT_W), one cycle later.
- R5: A line counter is cleared at frame start and incremented on each line start. When the incremented count equals the line-compare value, `line_base` becomes 0 instead of advancing, and later lines advance from 0.
- R6: With depth code 0 (8 bpp), `pan` equals the start byte offset bits 1:0.
- R7: With depth code 1 (15 bpp) or 2 (16 bpp), `pan` equals {0, byte offset bit 1}.
- R8: With depth code 3 (24 bpp), `pan` equals (4 − byte offset) modulo 4.
- R9: Writes to the start registers, the byte offset or the depth select during a frame do not change `line_base` or `pan` until the next frame start.
- R10: Bits of the extension start register at positions EXT_W and above are ignored.
- R11: When `frame_start` and `line_start` are high in the same cycle, the frame start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 8 | Register write data |
| frame_start | input | 1 | Frame-start strobe from the timing generator |
| line_start | input | 1 | Line-start strobe from the timing generator |
| depth | input | 2 | Colour depth code: 0 = 8, 1 = 15, 2 = 16, 3 = 24 bpp |
| line_base | output | 18+EXT_W | Byte address of the current scanline |
| pan | output | 2 | Pixel-pan value |

## Verification
The pan check sweeps all four byte offsets against all four depth codes. This separates the plain, the halved and the inverted encodings, and it exposes any swap of the depth codes. Line stepping is tried with several pitches: single-byte values, values that use both pitch bytes, and a pitch that carries the address past its top bit. These patterns separate errors in the ×8 scaling, errors in the pitch byte order and errors in the modulo wrap. A line-compare run shows the drop to zero at the exact line and the advance that follows. Further runs cover mid-frame rewrites, upper-bit writes to the extension register and coincident frame and line strobes, which show whether capture happens only at frame start and whether frame start has priority.

// File: rtl/scan_base_gen.sv
module scan_base_gen #(
  parameter int EXT_W  = 4,
  parameter int LINE_W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [2:0]          reg_sel,
  input  logic [7:0]          reg_wdata,
  input  logic                frame_start,
  input  logic                line_start,
  input  logic [1:0]          depth,
  output logic [18+EXT_W-1:0] line_base,
  output logic [1:0]          pan
);
  localparam int ADDR_W = 18 + EXT_W;
  localparam int WORD_W = ADDR_W - 2;

  logic [7:0]        start_lo, start_hi;
  logic [EXT_W-1:0]  start_ext;
  logic [1:0]        start_byte;
  logic [15:0]       pitch;
  logic [15:0]       lcmp_raw;
  logic [LINE_W-1:0] lcmp_val;
  logic [LINE_W-1:0] line_cnt;
  logic [LINE_W-1:0] next_cnt;
  logic [WORD_W-1:0] start_word;
  logic [ADDR_W-1:0] stride;
  logic [1:0]        pan_calc;

  assign start_word = {start_ext, start_hi, start_lo};
  assign stride     = ADDR_W'({pitch, 3'b000});
  assign lcmp_val   = lcmp_raw[LINE_W-1:0];
  assign next_cnt   = line_cnt + 1'b1;

  always_comb begin
    case (depth)
      2'd0:    pan_calc = start_byte;
      2'd1,
      2'd2:    pan_calc = {1'b0, start_byte[1]};
      default: pan_calc = 2'(3'd4 - {1'b0, start_byte});
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_lo   <= '0;
      start_hi   <= '0;
      start_ext  <= '0;
      start_byte <= '0;
      pitch      <= '0;
      lcmp_raw   <= '0;
    end else if (reg_wr) begin
      case (reg_sel)
        3'd0: start_lo        <= reg_wdata;
        3'd1: start_hi        <= reg_wdata;
        3'd2: start_ext       <= reg_wdata[EXT_W-1:0];
        3'd3: pitch[7:0]      <= reg_wdata;
        3'd4: pitch[15:8]     <= reg_wdata;
        3'd5: lcmp_raw[7:0]   <= reg_wdata;
        3'd6: lcmp_raw[15:8]  <= reg_wdata;
        default: start_byte   <= reg_wdata[1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_base <= '0;
      pan       <= '0;
      line_cnt  <= '0;
    end else if (frame_start) begin
      line_base <= {start_word, 2'b00};
      pan       <= pan_calc;
      line_cnt  <= '0;
    end else if (line_start) begin
      line_cnt  <= next_cnt;
      line_base <= (next_cnt == lcmp_val) ? '0 : line_base + stride;
    end
  end
endmodule

module scan_base_chk #(
  parameter int EXT_W  = 4,
  parameter int LINE_W = 11
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_start,
  input logic                line_start,
  input logic [1:0]          depth,
  input logic [18+EXT_W-1:0] line_base,
  input logic [1:0]          pan,
  input logic [LINE_W-1:0]   line_cnt,
  input logic [LINE_W-1:0]   lcmp_val,
  input logic [15:0]         start_word
);
  logic [LINE_W-1:0] cnt_inc;
  assign cnt_inc = line_cnt + 1'b1;

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (line_base == '0 && pan == 2'd0));
  p_frame_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> line_base[15:0] == {$past(start_word[13:0]), 2'b00});
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !line_start) |=> $stable(line_base));
  p_compare_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start && cnt_inc == lcmp_val) |=> line_base == '0);
  p_half_pan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && (depth == 2'd1 || depth == 2'd2)) |=> !pan[1]);
  p_pan_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(pan));
  p_frame_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && line_start) |=> line_cnt == '0);
endmodule

bind scan_base_gen scan_base_chk #(.EXT_W(EXT_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
  .depth(depth), .line_base(line_base), .pan(pan), .line_cnt(line_cnt),
  .lcmp_val(lcmp_val), .start_word(start_word[15:0])
);

// File: tb/tb_scan_base_gen.sv
`timescale 1ns/1ps
module tb_scan_base_gen;
  localparam int EXT_W  = 4;
  localparam int LINE_W = 11;
  localparam int ADDR_W = 18 + EXT_W;

  logic clk = 0, rst_n = 0, reg_wr = 0, frame_start = 0, line_start = 0;
  logic [2:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [1:0] depth = 0;
  logic [ADDR_W-1:0] line_base;
  logic [1:0] pan;

  int n_chk = 0, n_bad = 0;
  logic [ADDR_W-1:0] e_base = 0;
  logic [1:0]  e_pan = 0;
  int e_line = 0;
  int m_start = 0, m_pitch = 0, m_lcmp = 0;

  always #2 clk = ~clk;

  scan_base_gen #(.EXT_W(EXT_W), .LINE_W(LINE_W)) dut (.*);

  function automatic logic [1:0] pan_ref(input int d, input int b);
    case (d)
      0: return 2'(b);
      1, 2: return 2'((b >> 1) & 1);
      default: return 2'((4 - b) % 4);
    endcase
  endfunction

  task automatic check(input string req, input logic [ADDR_W-1:0] ab, input logic [1:0] ap,
                       input logic [ADDR_W-1:0] xb, input logic [1:0] xp);
    n_chk++;
    if (ab !== xb || ap !== xp) begin
      n_bad++;
      $display("FAIL %s: base=%h pan=%0d expected base=%h pan=%0d", req, ab, ap, xb, xp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk); reg_wr = 1; reg_sel = 3'(sel); reg_wdata = 8'(data);
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic set_start(input int a, input int ext_junk);
    wr(0, (a >> 2) & 8'hff);
    wr(1, (a >> 10) & 8'hff);
    wr(2, ((a >> 18) & 4'hf) | (ext_junk << 4));
    wr(7, a & 3);
    m_start = a;
  endtask

  task automatic set_pitch(input int p);
    wr(3, p & 8'hff); wr(4, (p >> 8) & 8'hff); m_pitch = p;
  endtask

  task automatic set_lcmp(input int l);
    wr(5, l & 8'hff); wr(6, (l >> 8) & 8'hff); m_lcmp = l;
  endtask

  task automatic do_frame(input logic with_line);
    @(negedge clk); frame_start = 1; line_start = with_line;
    @(negedge clk); frame_start = 0; line_start = 0;
    e_base = ADDR_W'(m_start & ~3);
    e_pan  = pan_ref(depth, m_start & 3);
    e_line = 0;
  endtask

  task automatic do_line();
    @(negedge clk); line_start = 1;
    @(negedge clk); line_start = 0;
    e_line = (e_line + 1) % (1 << LINE_W);
    if (e_line == m_lcmp) e_base = '0;
    else e_base = e_base + ADDR_W'(m_pitch * 8);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++; n_chk++;
    $display("FAIL watchdog: expired, expected run to finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    check("R1 in reset", line_base, pan, '0, 2'd0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 after reset", line_base, pan, '0, 2'd0);

    // R6 R7 R8 R3: byte offset x depth sweep
    for (int d = 0; d < 4; d++) begin
      for (int b = 0; b < 4; b++) begin
        depth = 2'(d);
        set_start(32'h12_3450 | b, 0);
        do_frame(0);
        check(d == 0 ? "R6 pan 8bpp" : (d == 3 ? "R8 pan 24bpp" : "R7 pan 15/16bpp"),
              line_base, pan, e_base, e_pan);
      end
    end

    // R4 R2: pitch stepping with several pitches, compare out of reach
    depth = 0;
    set_lcmp(2000);
    foreach (m_pitch_list[i]) begin
      set_pitch(m_pitch_list[i]);
      set_start(32'h00_1000 + i * 32'h4_0004, 0);
      do_frame(0);
      check("R3 frame load", line_base, pan, e_base, e_pan);
      for (int l = 0; l < 6; l++) begin
        do_line();
        check("R4 line step", line_base, pan, e_base, e_pan);
      end
    end

    // R4 wrap past the top address bit
    set_pitch(16'hffff);
    set_start(32'h3f_fff8, 0);
    do_frame(0);
    for (int l = 0; l < 3; l++) begin
      do_line();
      check("R4 wrap", line_base, pan, e_base, e_pan);
    end

    // R5 line compare
    set_pitch(16'h00a0);
    set_lcmp(5);
    set_start(32'h08_0000, 0);
    do_frame(0);
    for (int l = 0; l < 9; l++) begin
      do_line();
      check("R5 line compare", line_base, pan, e_base, e_pan);
    end
    set_lcmp(2000);

    // R10 upper extension bits ignored
    set_start(32'h0c_0000, 4'hf);
    do_frame(0);
    check("R10 ext upper ignored", line_base, pan, e_base, e_pan);
    set_start(32'h2c_0000, 4'h5);
    do_frame(0);
    check("R10 ext upper ignored", line_base, pan, e_base, e_pan);

    // R9 mid-frame rewrites take effect next frame
    depth = 0;
    set_pitch(16'h0010);
    set_start(32'h01_0001, 0);
    do_frame(0);
    do_line();
    begin
      int keep_start = m_start;
      set_start(32'h33_3332, 0);
      depth = 3;
      m_start = keep_start;
    end
    check("R9 hold after rewrite", line_base, pan, e_base, e_pan);
    do_line();
    check("R9 step uses old base", line_base, pan, e_base, e_pan);
    m_start = 32'h33_3332;
    do_frame(0);
    check("R9 next frame", line_base, pan, e_base, e_pan);

    // R11 frame start wins over line start
    depth = 1;
    set_start(32'h15_5553, 0);
    do_line();
    do_frame(1);
    check("R11 frame wins", line_base, pan, e_base, e_pan);
    do_line();
    check("R11 count restarted", line_base, pan, e_base, e_pan);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  int m_pitch_list[4] = '{1, 8'h50, 16'h0140, 16'h1234};
endmodule